// File: doc/BRIEF.md
# Two-Stage Cascaded Pacer Clock

This block generates a slow sampling pace from a fast reference clock. Two 16-bit down-counters run as rate generators in series. The first stage divides the reference and produces one low pulse per count period. Each rising edge of that output becomes a one-cycle enable, and the enable advances the second stage. The same enable is available for a spare counter outside the block. Both stages share one gate input. The block inverts the second stage's output to form the timer output, which is high for one first-stage period in every cycle of the product divider.

Software writes the two divisors through a simple write strobe. A select bit picks either the pacer or an alternative request line to drive the DMA request output. The output rate is the reference divided by the product of the two divisors. A new divisor takes effect at the next reload, so a count in progress is never cut short.

Top module: `pacer_cascade`

## Requirements
- R1: During and right after reset, `stage1_out` is high and `timer_out` is low. Both divisors reset to 2.
- R2: With the gate high, `stage1_out` goes low for exactly one clock every N1 clocks, where N1 is the stage-1 divisor. `stage1_tick` is high for one clock after each low pulse ends.
- R3: `timer_out` repeats every N1*N2 clocks and stays high for N1 clocks of each period, where N2 is the stage-2 divisor.
- R4: A written divisor value of 0 counts as 65536.
- R5: A write with data value 1 is ignored, and the divisor keeps its previous value.
- R6: A divisor written while a count is running does not change that count. The new value takes effect at the stage's next reload.
- R7: While `gate_in` is low, both counts hold, `stage1_out` is high and `timer_out` is low.
- R8: On the first clock with `gate_in` high after it was low, both stages load their divisors. The first `stage1_out` low then comes N1 clocks later.
- R9: `dma_req` equals `timer_out` when `req_sel` is 1, and equals `alt_req` when `req_sel` is 0.
- R10: The second stage changes its count only on a `stage1_tick` or on a reload.
- R11: A write with `wr_en` high goes to the stage-1 divisor when `wr_sel` is 0 and to the stage-2 divisor when `wr_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (10 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_in | input | 1 | Shared gate for both stages; high lets them count |
| wr_en | input | 1 | Divisor write strobe |
| wr_sel | input | 1 | Divisor select: 0 = stage 1, 1 = stage 2 |
| wr_data | input | 16 | Divisor value (0 means 65536; 1 is rejected) |
| req_sel | input | 1 | 1 = pacer drives `dma_req`, 0 = `alt_req` does |
| alt_req | input | 1 | Alternative request source |
| stage1_out | output | 1 | Stage-1 rate output, low one clock per period |
| stage1_tick | output | 1 | One-clock enable on the rising edge of `stage1_out` |
| timer_out | output | 1 | Inverted stage-2 output |
| dma_req | output | 1 | Selected DMA request |

## Verification
The bench measures the `timer_out` period and high time for several divisor pairs. If the cascade multiplied the wrong way, or took its edge from the falling side, the period or the pulse width would be off. It writes a divisor in the middle of a count: a design that loads immediately would shorten the running period instead of the next one. It also checks that a divisor of 1 is refused and that 0 gives a full 65536-clock period; a wrong design would lock the output or wrap early. It drops the gate, then raises it and times the first pulse. A design that kept counting while gated, or failed to reload, would show a shifted or missing pulse.

// File: rtl/pacer_cascade.sv
module pacer_cascade #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] DIV_RST = W'(2)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_in,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         req_sel,
  input  logic         alt_req,
  output logic         stage1_out,
  output logic         stage1_tick,
  output logic         timer_out,
  output logic         dma_req
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] div1_q, div2_q;
  logic [W-1:0] cnt1, cnt2;
  logic         pend;
  logic         o1_q;
  logic         live;
  logic         wr_ok;

  assign wr_ok = wr_en && (wr_data != ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div1_q <= DIV_RST;
      div2_q <= DIV_RST;
    end else if (wr_ok) begin
      if (wr_sel) div2_q <= wr_data;
      else        div1_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b1;
      cnt1 <= '0;
      cnt2 <= '0;
    end else if (!gate_in) begin
      pend <= 1'b1;
    end else if (pend) begin
      pend <= 1'b0;
      cnt1 <= div1_q;
      cnt2 <= div2_q;
    end else begin
      cnt1 <= (cnt1 == ONE) ? div1_q : cnt1 - ONE;
      if (stage1_tick)
        cnt2 <= (cnt2 == ONE) ? div2_q : cnt2 - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) o1_q <= 1'b1;
    else        o1_q <= stage1_out;
  end

  assign live        = gate_in & ~pend;
  assign stage1_out  = ~(live & (cnt1 == ONE));
  assign stage1_tick = stage1_out & ~o1_q;
  assign timer_out   = live & (cnt2 == ONE);
  assign dma_req     = req_sel ? timer_out : alt_req;

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_in |=> $stable(cnt1) && $stable(cnt2)); // R7
  AST_GATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pend && gate_in |=> (cnt1 == $past(div1_q)) && (cnt2 == $past(div2_q))); // R8
  AST_NO_UNIT_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (div1_q != ONE) && (div2_q != ONE)); // R5
  AST_CASCADE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !stage1_tick && !pend |=> $stable(cnt2)); // R10
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stage1_tick |=> !stage1_tick); // R2
  AST_LOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !stage1_out |=> stage1_out); // R2

endmodule

// File: tb/pacer_cascade_bench.sv
module pacer_cascade_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_in = 1'b1;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic req_sel = 1'b0;
  logic alt_req = 1'b1;
  logic stage1_out, stage1_tick, timer_out, dma_req;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pacer_cascade u_pacer_cascade (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .req_sel(req_sel), .alt_req(alt_req),
    .stage1_out(stage1_out), .stage1_tick(stage1_tick),
    .timer_out(timer_out), .dma_req(dma_req)
  );

  // {N1, N2, period, high width}
  localparam logic [63:0] VEC [5] = '{
    {16'd2,  16'd2, 16'd4,  16'd2},
    {16'd3,  16'd5, 16'd15, 16'd3},
    {16'd7,  16'd4, 16'd28, 16'd7},
    {16'd10, 16'd3, 16'd30, 16'd10},
    {16'd2,  16'd9, 16'd18, 16'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_div(input logic sel, input logic [15:0] val);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic to_fall(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (stage1_out);
  endtask

  task automatic timer_meas(output int per, output int wid);
    do @(negedge clk); while (timer_out);
    do @(negedge clk); while (!timer_out);
    per = 0; wid = 0;
    while (timer_out) begin wid++; @(negedge clk); per++; end
    while (!timer_out) begin @(negedge clk); per++; end
  endtask

  initial begin
    #(190000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, per, wid;
    repeat (3) @(negedge clk);
    check(stage1_out === 1'b1, "R1 stage1_out in reset", stage1_out, 1);
    check(timer_out === 1'b0, "R1 timer_out in reset", timer_out, 0);
    check(dma_req === 1'b1, "R9 alt_req routed", dma_req, 1);
    rst_n = 1'b1;
    to_fall(n); to_fall(n);
    check(n == 2, "R1 reset divisor period", n, 2);

    foreach (VEC[i]) begin
      @(negedge clk); gate_in = 1'b0;
      write_div(1'b0, VEC[i][63:48]);
      write_div(1'b1, VEC[i][47:32]);
      @(negedge clk); gate_in = 1'b1;
      timer_meas(per, wid);
      check(per == int'(VEC[i][31:16]), "R3 R11 timer period", per, int'(VEC[i][31:16]));
      check(wid == int'(VEC[i][15:0]), "R3 timer high width", wid, int'(VEC[i][15:0]));
    end

    // R9 pacer as request source
    req_sel = 1'b1;
    do @(negedge clk); while (!timer_out);
    check(dma_req === 1'b1, "R9 dma_req follows timer high", dma_req, 1);
    do @(negedge clk); while (timer_out);
    check(dma_req === 1'b0, "R9 dma_req follows timer low", dma_req, 0);
    req_sel = 1'b0;
    #1;
    check(dma_req === alt_req, "R9 dma_req back to alt_req", dma_req, alt_req);

    // R7 gate freeze
    @(negedge clk); gate_in = 1'b0;
    write_div(1'b0, 16'd6);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!stage1_out || timer_out || stage1_tick) n++;
    end
    check(n == 0, "R7 outputs idle while gated", n, 0);

    // R8 reload on gate rise
    gate_in = 1'b1;
    to_fall(n);
    check(n == 6, "R8 first pulse after gate", n, 6);
    to_fall(n);
    check(n == 6, "R2 stage1 period", n, 6);

    // R6 mid-count write
    write_div(1'b0, 16'd20);
    to_fall(n); to_fall(n);
    check(n == 20, "R6 period before change", n, 20);
    n = 0;
    repeat (4) begin @(negedge clk); n++; end
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'd6;
    @(negedge clk); n++; wr_en = 1'b0;
    while (stage1_out) begin @(negedge clk); n++; end
    check(n == 20, "R6 running count unchanged", n, 20);
    to_fall(n);
    check(n == 6, "R6 new divisor after reload", n, 6);

    // R5 write of 1 ignored
    write_div(1'b0, 16'd1);
    to_fall(n); to_fall(n);
    check(n == 6, "R5 unit divisor rejected", n, 6);

    // R4 zero means 65536
    @(negedge clk); gate_in = 1'b0;
    write_div(1'b0, 16'd0);
    @(negedge clk); gate_in = 1'b1;
    to_fall(n);
    check(n == 65536, "R4 zero divisor first pulse", n, 65536);
    to_fall(n);
    check(n == 65536, "R4 zero divisor period", n, 65536);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule